// File: doc/BRIEF.md
# Dual Real-Time-Clock Waveform Output Generator

This block drives two output pins from the timebase of a real-time clock. Each pin has its own 3-bit source select. A select can hold the pin low or pick a 50% square wave at 1, 32, 64 or 512 Hz. It can also pick a signal built from the alarm flag, either a level copy or a state that flips on each alarm rise. The last choice is a pulse train from a generator that both pins share; its high time and repetition period are chosen by code.

The block runs on the system clock `clk`. The timebase comes in as a single-cycle enable, `tick_2x`, that pulses at twice the 32.768 kHz reference rate, which is 65536 pulses per second. Every source is derived from one binary counter of those pulses. The half-reference-cycle pulse width therefore needs no second clock. Both outputs are registers and change only on a `tick_2x` cycle. A change of select therefore shows up cleanly at the next tick, with no glitch.

Top module: `rtc_wave_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, both outputs, the alarm-toggle state and the tick counter are zero.
- R2: Select value 0 holds the pin at 0.
- R3: Select values 1, 2, 3 and 4 give square waves of 50% duty from the count n of `tick_2x` pulses since reset (modulo 65536). The pin is bit 15, 10, 9 or 6 of n, which gives 1 Hz, 32 Hz, 64 Hz and 512 Hz.
- R4: Select value 5 gives a toggle state. It inverts on each rising edge of `alarm`, seen on `clk`, and is unchanged by falling edges and by a steady level.
- R5: Select value 6 copies the level of `alarm` sampled at the tick.
- R6: Select value 7 gives the pulse train. It is high while the position inside the period is below the high length, so it rises at the start of each period. `high_code` 0 to 7 gives high lengths of 2048, 1024, 256, 64, 32, 8, 2 and 1 ticks (31.2 ms down to 15.2 us).
- R7: `period_code` 0 to 3 sets the pulse period to 65536, 32768, 16384 or 8192 ticks (1 s, 500 ms, 250 ms, 125 ms). The position inside the period is n modulo that length.
- R8: An output changes only on the clock edge that samples `tick_2x` high. At that edge it takes the value of its source for the incremented count n.
- R9: Each pin decodes its own select, so the two pins can carry different sources at the same time.
- R10: A new select value takes effect at the first tick after it is applied. Between ticks the output holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_2x | input | 1 | Single-cycle enable at twice the 32.768 kHz reference rate |
| alarm | input | 1 | Alarm flag level |
| sel0 | input | 3 | Source select for pin 0 |
| sel1 | input | 3 | Source select for pin 1 |
| high_code | input | 3 | Pulse high-duration code |
| period_code | input | 2 | Pulse period code |
| wave0 | output | 1 | Waveform output pin 0 |
| wave1 | output | 1 | Waveform output pin 1 |

## Verification
Each output is due one clock after the edge that samples `tick_2x` high, and it holds through every clock without a tick. The alarm-toggle state moves one clock after an alarm rise and reaches a pin only at the next tick. The bench model follows the same timing. At each rising edge it advances its own tick count, its toggle state and its expected pin values from the inputs held at that edge, and it compares against the pins on the following falling edge. Inputs change only on falling edges, so every comparison sees settled values from one edge.

// File: rtl/rtc_wave_pkg.sv
package rtc_wave_pkg;

  typedef enum logic [2:0] {
    SRC_LOW     = 3'd0,
    SRC_1HZ     = 3'd1,
    SRC_32HZ    = 3'd2,
    SRC_64HZ    = 3'd3,
    SRC_512HZ   = 3'd4,
    SRC_ALM_TGL = 3'd5,
    SRC_ALM_LVL = 3'd6,
    SRC_PULSE   = 3'd7
  } wave_src_e;

  localparam int NUM_SRC = 8;

  // log2 of the pulse high length in double-rate ticks
  function automatic int unsigned high_shift(input logic [2:0] code);
    case (code)
      3'd0:    high_shift = 11;
      3'd1:    high_shift = 10;
      3'd2:    high_shift = 8;
      3'd3:    high_shift = 6;
      3'd4:    high_shift = 5;
      3'd5:    high_shift = 3;
      3'd6:    high_shift = 1;
      default: high_shift = 0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_2x,
  output logic [DIV_W-1:0] cnt_nx
);
  logic [DIV_W-1:0] cnt_q;

  assign cnt_nx = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_2x) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/rtc_pulse_shaper.sv
module rtc_pulse_shaper
  import rtc_wave_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W-1:0] cnt_nx,
  input  logic [2:0]       high_code,
  input  logic [1:0]       period_code,
  output logic             pulse_lvl
);
  localparam logic [DIV_W-1:0] ALL_ONES = '1;
  localparam logic [DIV_W-1:0] ONE      = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] pos;
  logic [DIV_W-1:0] high_len;

  always_comb begin
    pos       = cnt_nx & (ALL_ONES >> period_code);
    high_len  = ONE << high_shift(high_code);
    pulse_lvl = (pos < high_len);
  end
endmodule

// File: rtl/rtc_alarm_tracker.sv
module rtc_alarm_tracker (
  input  logic clk,
  input  logic rst,
  input  logic alarm,
  output logic tog_q
);
  logic alarm_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_d <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      alarm_d <= alarm;
      if (alarm && !alarm_d) tog_q <= !tog_q;
    end
  end
endmodule

// File: rtl/rtc_wave_select.sv
module rtc_wave_select
  import rtc_wave_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_2x,
  input  logic [2:0]         sel,
  input  logic [NUM_SRC-1:0] src,
  output logic               wave_q
);
  always_ff @(posedge clk) begin
    if (rst)          wave_q <= 1'b0;
    else if (tick_2x) wave_q <= src[sel];
  end
endmodule

// File: rtl/rtc_wave_gen.sv
module rtc_wave_gen
  import rtc_wave_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int NUM_OUT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_2x,
  input  logic       alarm,
  input  logic [2:0] sel0,
  input  logic [2:0] sel1,
  input  logic [2:0] high_code,
  input  logic [1:0] period_code,
  output logic       wave0,
  output logic       wave1
);
  // Counter bit whose toggling rate gives each square-wave frequency
  localparam int BIT_1HZ   = DIV_W - 1;
  localparam int BIT_32HZ  = DIV_W - 6;
  localparam int BIT_64HZ  = DIV_W - 7;
  localparam int BIT_512HZ = DIV_W - 10;

  logic [DIV_W-1:0]   cnt_nx;
  logic               pulse_lvl;
  logic               tog_q;
  logic [NUM_SRC-1:0] src;
  logic [2:0]         sel_arr  [NUM_OUT];
  logic               wave_arr [NUM_OUT];

  rtc_tick_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .tick_2x(tick_2x), .cnt_nx(cnt_nx)
  );

  rtc_pulse_shaper #(.DIV_W(DIV_W)) u_pulse (
    .cnt_nx(cnt_nx), .high_code(high_code), .period_code(period_code),
    .pulse_lvl(pulse_lvl)
  );

  rtc_alarm_tracker u_alarm (
    .clk(clk), .rst(rst), .alarm(alarm), .tog_q(tog_q)
  );

  always_comb begin
    src              = '0;
    src[SRC_LOW]     = 1'b0;
    src[SRC_1HZ]     = cnt_nx[BIT_1HZ];
    src[SRC_32HZ]    = cnt_nx[BIT_32HZ];
    src[SRC_64HZ]    = cnt_nx[BIT_64HZ];
    src[SRC_512HZ]   = cnt_nx[BIT_512HZ];
    src[SRC_ALM_TGL] = tog_q;
    src[SRC_ALM_LVL] = alarm;
    src[SRC_PULSE]   = pulse_lvl;
  end

  assign sel_arr[0] = sel0;
  assign sel_arr[1] = sel1;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    rtc_wave_select u_sel (
      .clk(clk), .rst(rst), .tick_2x(tick_2x),
      .sel(sel_arr[i]), .src(src), .wave_q(wave_arr[i])
    );
  end

  assign wave0 = wave_arr[0];
  assign wave1 = wave_arr[1];
endmodule

// File: rtl/rtc_wave_checker.sv
module rtc_wave_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick_2x,
  input logic       alarm,
  input logic [2:0] sel0,
  input logic [2:0] sel1,
  input logic       wave0,
  input logic       wave1,
  input logic       tog
);
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!wave0 && !wave1 && !tog));

  p_const_low_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_2x && sel0 == 3'd0) |=> !wave0);

  p_fall_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    !alarm |=> $stable(tog));

  p_alarm_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (tick_2x && sel1 == 3'd6) |=> (wave1 == $past(alarm)));

  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
    !tick_2x |=> ($stable(wave0) && $stable(wave1)));
endmodule

bind rtc_wave_gen rtc_wave_checker u_chk (
  .clk(clk), .rst(rst), .tick_2x(tick_2x), .alarm(alarm),
  .sel0(sel0), .sel1(sel1), .wave0(wave0), .wave1(wave1), .tog(tog_q)
);

// File: tb/rtc_wave_gen_tb.sv
module rtc_wave_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_2x = 1'b0;
  logic       alarm = 1'b0;
  logic [2:0] sel0 = 3'd0;
  logic [2:0] sel1 = 3'd0;
  logic [2:0] high_code = 3'd0;
  logic [1:0] period_code = 2'd0;
  logic       wave0, wave1;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string req_tag = "R1";
  bit    done = 0;

  // reference model state
  int n = 0;
  bit tg = 0, ap = 0, e0 = 0, e1 = 0;

  always #5 clk = ~clk;

  rtc_wave_gen u_dut (
    .clk(clk), .rst(rst), .tick_2x(tick_2x), .alarm(alarm),
    .sel0(sel0), .sel1(sel1), .high_code(high_code),
    .period_code(period_code), .wave0(wave0), .wave1(wave1)
  );

  function automatic int hi_len(input int code);
    case (code)
      0: return 2048;  1: return 1024; 2: return 256; 3: return 64;
      4: return 32;    5: return 8;    6: return 2;   default: return 1;
    endcase
  endfunction

  function automatic bit srcval(input int s, input int cnt, input bit t, input bit a);
    case (s)
      0: return 1'b0;
      1: return ((cnt / 32768) % 2) == 1;
      2: return ((cnt / 1024) % 2) == 1;
      3: return ((cnt / 512) % 2) == 1;
      4: return ((cnt / 64) % 2) == 1;
      5: return t;
      6: return a;
      default: return (cnt % (65536 >> period_code)) < hi_len(int'(high_code));
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      n = 0; tg = 0; ap = 0; e0 = 0; e1 = 0;
    end else begin
      if (tick_2x) begin
        n  = (n + 1) % 65536;
        e0 = srcval(int'(sel0), n, tg, alarm);
        e1 = srcval(int'(sel1), n, tg, alarm);
      end
      if (alarm && !ap) tg = !tg;
      ap = alarm;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      checks++;
      if (wave0 !== e0) begin
        fails++;
        $display("FAIL %s wave0 cycle %0d got %0b expected %0b", req_tag, cyc, wave0, e0);
      end
      checks++;
      if (wave1 !== e1) begin
        fails++;
        $display("FAIL %s wave1 cycle %0d got %0b expected %0b", req_tag, cyc, wave1, e1);
      end
    end
    if (cyc > 195000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired got cycle %0d expected below 195000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input int cycles, input bit sparse);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      tick_2x = sparse ? ((k % 3) == 0) : 1'b1;
    end
  endtask

  initial begin
    // R1: reset state checked by the per-cycle comparison
    req_tag = "R1";
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: first cycle after reset, no tick yet
    @(negedge clk);

    // R2 and R9: pin 0 constant low while pin 1 carries 512 Hz
    req_tag = "R2_R9"; sel0 = 3'd0; sel1 = 3'd4;
    run(300, 0);

    // R3: 1 Hz against 32 Hz, then 64 Hz against 512 Hz
    req_tag = "R3"; sel0 = 3'd1; sel1 = 3'd2;
    run(33000, 0);
    sel0 = 3'd3; sel1 = 3'd4;
    run(2000, 0);

    // R4 and R5: toggle on rises only, level copy; sparse ticks
    req_tag = "R4_R5"; sel0 = 3'd5; sel1 = 3'd6;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); alarm = 1'b1; tick_2x = (k % 2) == 0;
      run(1 + (k % 4), 1);
      @(negedge clk); alarm = 1'b0; tick_2x = 1'b0;
      run(2 + (k % 5), (k % 3) == 0);
    end
    run(10, 0);

    // R8 and R10: select changes between sparse ticks
    req_tag = "R8_R10";
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); tick_2x = 1'b0;
      sel0 = 3'(k % 8); sel1 = 3'((k + 3) % 8);
      run(5, 1);
    end

    // R7: each period code with a fixed high length
    req_tag = "R7"; sel0 = 3'd7; sel1 = 3'd1; high_code = 3'd2;
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); period_code = 2'(p);
      run(20000, 0);
    end

    // R6: every high-length code at the shortest period
    req_tag = "R6"; sel1 = 3'd7; period_code = 2'd3;
    for (int h = 0; h < 8; h++) begin
      @(negedge clk); high_code = 3'(h);
      run(8300, 0);
    end

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule